// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It supports register arithmetic and logic (add, sub, and, or, set-less-than), an OR with an immediate, word load and store, branch-if-equal and an absolute jump. Decoding runs in two stages. A main decoder turns the 6-bit opcode into datapath controls and a 2-bit ALU class. A second stage turns that class, and the function field for register operations, into the 3-bit ALU operation.

Instruction and data storage are small word arrays inside the core. While reset is held, a load port fills either array one word at a time. After reset is released, execution starts at address 0. Every retired instruction leaves a registered retire record on the outputs: its PC, any register write and any store. That record is how surrounding logic, or a bench, follows execution.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and `ret_valid` is low. The first record after reset is released carries `ret_pc` = 0.
- R2: Opcode 000000 is a register operation writing rd. funct[3:0] picks the ALU operation: 0000 add, 0010 sub, 0100 and, 0101 or, 1010 set-less-than. funct bits 5 and 4 have no effect on the choice.
- R3: Set-less-than writes 1 when rs < rt as signed 32-bit values, and 0 otherwise.
- R4: Opcode 001101 ORs rs with the zero-extended 16-bit immediate and writes rt.
- R5: Opcode 100011 reads the data word at rs plus the sign-extended immediate and writes it to rt. The word index is taken from address bits above bit 1.
- R6: Opcode 101011 writes rt to the data word at rs plus the sign-extended immediate. It writes no register. The record shows `ret_st` high with the byte address and the store data.
- R7: Opcode 000100 compares rs and rt by subtraction and writes no register. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, with negative offsets allowed. Otherwise the next PC is PC+4.
- R8: Opcode 000010 sets the next PC to bits 31:28 of PC+4, then the 26-bit target, then 00.
- R9: Register 0 reads as zero. A write aimed at it is dropped and shows `ret_wen` low.
- R10: Any other opcode writes nothing and only advances the PC by 4.
- R11: Exactly one instruction retires per clock after reset. Its record appears on the outputs after the edge that executes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load port write strobe |
| ld_dmem | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr | input | LD_AW (6) | Word index for the load port |
| ld_data | input | XLEN (32) | Word written by the load port |
| ret_valid | output | 1 | A retire record is present |
| ret_pc | output | XLEN | PC of the retired instruction |
| ret_wen | output | 1 | The instruction wrote a register (never register 0) |
| ret_wreg | output | 5 | Destination register index |
| ret_wdata | output | XLEN | Value written to the register |
| ret_st | output | 1 | The instruction stored to data memory |
| ret_addr | output | XLEN | Byte address of the store |
| ret_sdata | output | XLEN | Data stored |

## Verification
The assertions assume that the load port is used only while reset is held, so fetch never sees a word change under it. They also assume that reset lasts at least one edge before execution begins. They further take for granted that programs keep data addresses inside the data array and branch and jump targets inside the instruction array, because out-of-range addresses wrap silently. The stimulus loads all code and data during a long reset. Its program reaches only loaded words and in-range data addresses, and jumps over the unused regions of the array.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LDW  = 6'b100011;
  localparam logic [5:0] OP_STW  = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CL_ADD   = 2'b00,
    CL_SUB   = 2'b01,
    CL_FUNCT = 2'b10,
    CL_OR    = 2'b11
  } alu_cls_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     alu_imm;
    logic     zext;
    logic     mem_to_reg;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, zext: 1'b0,
             mem_to_reg: 1'b0, mem_we: 1'b0, branch: 1'b0, jump: 1'b0,
             cls: CL_ADD};
    case (op)
      OP_REG: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst_rd = 1'b1;
        ctrl.cls    = CL_FUNCT;
      end
      OP_LDW: begin
        ctrl.reg_we     = 1'b1;
        ctrl.alu_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STW: begin
        ctrl.alu_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CL_SUB;
      end
      OP_ORI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.alu_imm = 1'b1;
        ctrl.zext    = 1'b1;
        ctrl.cls     = CL_OR;
      end
      OP_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  logic unused_hi;
  assign unused_hi = ^funct[5:4];

  always_comb begin
    case (cls)
      CL_ADD: fn = FN_ADD;
      CL_SUB: fn = FN_SUB;
      CL_OR:  fn = FN_OR;
      default: begin
        case (funct[3:0])
          4'b0000: fn = FN_ADD;
          4'b0010: fn = FN_SUB;
          4'b0100: fn = FN_AND;
          4'b0101: fn = FN_OR;
          4'b1010: fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int  XLEN    = 32,
  parameter int  IMEM_AW = 6,
  parameter int  DMEM_AW = 6,
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic             ret_valid,
  output logic [XLEN-1:0]  ret_pc,
  output logic             ret_wen,
  output logic [4:0]       ret_wreg,
  output logic [XLEN-1:0]  ret_wdata,
  output logic             ret_st,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  ret_sdata
);
  localparam int IMW = 16;
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc, pc_plus4, pc_br, pc_jmp, pc_next;
  logic [XLEN-1:0] instr, imm_ext, alu_b, alu_y, wb_data, dm_rd;
  logic [5:0]      op, funct;
  logic [4:0]      rs, rt, rd, wreg;
  logic [IMW-1:0]  imm;
  ctrl_t           ctrl;
  alu_fn_e         fn;
  logic            alu_zero;
  logic [1:0][4:0]      rf_ra;
  logic [1:0][XLEN-1:0] rf_rd;

  // fetch and field split
  assign instr = imem[pc[IMEM_AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign imm   = instr[IMW-1:0];

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], instr[10:6], alu_y[1:0]};

  sc_main_ctrl u_main (.op(op), .ctrl(ctrl));
  sc_alu_ctrl  u_actl (.cls(ctrl.cls), .funct(funct), .fn(fn));

  assign rf_ra[0] = rs;
  assign rf_ra[1] = rt;
  assign wreg     = ctrl.dst_rd ? rd : rt;

  sc_regfile #(.W(XLEN), .DEPTH(32), .NRD(2)) u_rf (
    .clk(clk), .we(ctrl.reg_we && !rst), .waddr(wreg), .wdata(wb_data),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  assign imm_ext = ctrl.zext ? {{(XLEN-IMW){1'b0}}, imm}
                             : {{(XLEN-IMW){imm[IMW-1]}}, imm};
  assign alu_b   = ctrl.alu_imm ? imm_ext : rf_rd[1];

  sc_alu #(.W(XLEN)) u_alu (
    .a(rf_rd[0]), .b(alu_b), .fn(fn), .y(alu_y), .zero(alu_zero)
  );

  assign dm_rd   = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data = ctrl.mem_to_reg ? dm_rd : alu_y;

  // next PC selection
  assign pc_plus4 = pc + XLEN'(4);
  assign pc_br    = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_jmp   = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
  always_comb begin
    if (ctrl.jump)                  pc_next = pc_jmp;
    else if (ctrl.branch && alu_zero) pc_next = pc_br;
    else                            pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // storage arrays: one write port each
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)           dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (!rst && ctrl.mem_we)   dmem[alu_y[DMEM_AW+1:2]]   <= rf_rd[1];
  end

  // registered retire record
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_wen   <= 1'b0;
      ret_wreg  <= '0;
      ret_wdata <= '0;
      ret_st    <= 1'b0;
      ret_addr  <= '0;
      ret_sdata <= '0;
    end else begin
      ret_valid <= 1'b1;
      ret_pc    <= pc;
      ret_wen   <= ctrl.reg_we && (wreg != 5'd0);
      ret_wreg  <= wreg;
      ret_wdata <= wb_data;
      ret_st    <= ctrl.mem_we;
      ret_addr  <= alu_y;
      ret_sdata <= rf_rd[1];
    end
  end

  logic op_known;
  assign op_known = (op == OP_REG) || (op == OP_LDW) || (op == OP_STW) ||
                    (op == OP_BEQ) || (op == OP_ORI) || (op == OP_JMP);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc == '0) && !ret_valid);

  // R11
  retire_each_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ret_valid && (ret_pc == $past(pc)));

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ret_st |-> !ret_wen);

  // R9
  zero_reg_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ret_wen |-> (ret_wreg != 5'd0));

  // R7
  branch_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && (rf_rd[0] != rf_rd[1])) |=> (pc == $past(pc) + XLEN'(4)));

  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    !op_known |=> !ret_wen && !ret_st && (pc == $past(pc) + XLEN'(4)));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ret_valid, ret_wen, ret_st;
  logic [31:0] ret_pc, ret_wdata, ret_addr, ret_sdata;
  logic [4:0]  ret_wreg;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_wen(ret_wen), .ret_wreg(ret_wreg),
    .ret_wdata(ret_wdata), .ret_st(ret_st), .ret_addr(ret_addr),
    .ret_sdata(ret_sdata)
  );

  typedef struct {
    logic [31:0] pc;
    logic        wen;
    logic [4:0]  wreg;
    logic [31:0] wdata;
    logic        st;
    logic [31:0] addr;
    logic [31:0] sdata;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 0;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] o, int s, int t, logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'b000010, 26'(tgt)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic load(bit to_d, int idx, logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = to_d; ld_addr = 6'(idx); ld_data = w;
  endtask

  // driver: push one expected retire record
  task automatic expect_ret(logic [31:0] pc, logic wen, int wr, logic [31:0] wd,
                            logic st, logic [31:0] ad, logic [31:0] sd, string tag);
    exp_t e;
    e.pc = pc; e.wen = wen; e.wreg = 5'(wr); e.wdata = wd;
    e.st = st; e.addr = ad; e.sdata = sd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pop and compare each retire record
  always @(negedge clk) begin
    if (!rst && ret_valid && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "R11 ret_pc", ret_pc, e.pc);
      chk(e.tag, "ret_wen", 32'(ret_wen), 32'(e.wen));
      if (e.wen) begin
        chk(e.tag, "ret_wreg", 32'(ret_wreg), 32'(e.wreg));
        chk(e.tag, "ret_wdata", ret_wdata, e.wdata);
      end
      chk(e.tag, "ret_st", 32'(ret_st), 32'(e.st));
      if (e.st) begin
        chk(e.tag, "ret_addr", ret_addr, e.addr);
        chk(e.tag, "ret_sdata", ret_sdata, e.sdata);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d records left expected 0", q.size());
    finish_run();
  end

  initial begin
    // program, loaded while reset holds
    load(0, 0,  enc_i(6'h0D, 0, 1, 16'h8005));
    load(0, 1,  enc_i(6'h23, 0, 2, 16'h0004));
    load(0, 2,  enc_i(6'h0D, 0, 3, 16'h000C));
    load(0, 3,  enc_i(6'h23, 3, 4, 16'hFFFC));
    load(0, 4,  enc_r(1, 4, 5, 6'h20));
    load(0, 5,  enc_r(4, 1, 6, 6'h22));
    load(0, 6,  enc_r(1, 6, 7, 6'h24));
    load(0, 7,  enc_r(1, 2, 8, 6'h25));
    load(0, 8,  enc_r(2, 4, 9, 6'h2A));
    load(0, 9,  enc_r(4, 2, 10, 6'h0A));
    load(0, 10, enc_r(4, 3, 11, 6'h12));
    load(0, 11, enc_r(1, 1, 0, 6'h20));
    load(0, 12, enc_r(0, 1, 12, 6'h20));
    load(0, 13, enc_i(6'h2B, 3, 5, 16'h0008));
    load(0, 14, enc_i(6'h23, 0, 13, 16'h0014));
    load(0, 15, enc_i(6'h04, 4, 3, 16'h0005));
    load(0, 16, enc_i(6'h04, 9, 9, 16'h0002));
    load(0, 17, enc_i(6'h0D, 0, 14, 16'hDEAD));
    load(0, 18, enc_i(6'h0D, 0, 14, 16'hDEAD));
    load(0, 19, enc_j(22));
    load(0, 20, enc_i(6'h0D, 0, 14, 16'hBEEF));
    load(0, 21, enc_i(6'h0D, 0, 14, 16'hBEEF));
    load(0, 22, {6'h3F, 5'd1, 5'd20, 16'h0001});
    load(0, 23, enc_i(6'h04, 0, 0, 16'h0001));
    load(0, 24, enc_i(6'h0D, 0, 14, 16'hCAFE));
    load(0, 25, enc_j(30));
    load(0, 26, enc_i(6'h0D, 0, 15, 16'h1234));
    load(0, 27, enc_j(40));
    load(0, 30, enc_i(6'h04, 12, 1, 16'hFFFB));
    load(0, 40, enc_r(15, 13, 16, 6'h20));
    load(1, 1, 32'hFFFF_FFF0);
    load(1, 2, 32'h0000_0007);
    @(negedge clk);
    ld_en = 1'b0;
    // R1: no record while reset holds
    chk("R1", "ret_valid in reset", 32'(ret_valid), 32'd0);

    expect_ret(32'd0,   1, 1,  32'h0000_8005, 0, 0, 0, "R4 ori zero-ext, R1 first pc");
    expect_ret(32'd4,   1, 2,  32'hFFFF_FFF0, 0, 0, 0, "R5 lw");
    expect_ret(32'd8,   1, 3,  32'h0000_000C, 0, 0, 0, "R4 ori");
    expect_ret(32'd12,  1, 4,  32'h0000_0007, 0, 0, 0, "R5 lw negative offset");
    expect_ret(32'd16,  1, 5,  32'h0000_800C, 0, 0, 0, "R2 add");
    expect_ret(32'd20,  1, 6,  32'hFFFF_8002, 0, 0, 0, "R2 sub");
    expect_ret(32'd24,  1, 7,  32'h0000_8000, 0, 0, 0, "R2 and");
    expect_ret(32'd28,  1, 8,  32'hFFFF_FFF5, 0, 0, 0, "R2 or");
    expect_ret(32'd32,  1, 9,  32'h0000_0001, 0, 0, 0, "R3 slt true");
    expect_ret(32'd36,  1, 10, 32'h0000_0000, 0, 0, 0, "R3 slt false, R2 funct hi ignored");
    expect_ret(32'd40,  1, 11, 32'hFFFF_FFFB, 0, 0, 0, "R2 sub funct hi ignored");
    expect_ret(32'd44,  0, 0,  32'h0,         0, 0, 0, "R9 write to r0 dropped");
    expect_ret(32'd48,  1, 12, 32'h0000_8005, 0, 0, 0, "R9 r0 reads zero");
    expect_ret(32'd52,  0, 0,  32'h0,         1, 32'd20, 32'h0000_800C, "R6 sw");
    expect_ret(32'd56,  1, 13, 32'h0000_800C, 0, 0, 0, "R6 stored word read back");
    expect_ret(32'd60,  0, 0,  32'h0,         0, 0, 0, "R7 beq not taken");
    expect_ret(32'd64,  0, 0,  32'h0,         0, 0, 0, "R7 beq taken");
    expect_ret(32'd76,  0, 0,  32'h0,         0, 0, 0, "R8 j");
    expect_ret(32'd88,  0, 0,  32'h0,         0, 0, 0, "R10 unknown opcode");
    expect_ret(32'd92,  0, 0,  32'h0,         0, 0, 0, "R10 next pc, R7 beq r0");
    expect_ret(32'd100, 0, 0,  32'h0,         0, 0, 0, "R7 taken target");
    expect_ret(32'd120, 0, 0,  32'h0,         0, 0, 0, "R8 j target");
    expect_ret(32'd104, 1, 15, 32'h0000_1234, 0, 0, 0, "R7 backward branch");
    expect_ret(32'd108, 0, 0,  32'h0,         0, 0, 0, "R8 j");
    expect_ret(32'd160, 1, 16, 32'h0000_9240, 0, 0, 0, "R8 j target, R11");

    @(negedge clk);
    rst = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule